// File: doc/BRIEF.md
# Binary Event Array Row Scan Sequencer

This block controls a two-dimensional array of pixels that each report two status flags per frame: one bit when the signal has risen above its upper tracking bound and one bit when it has fallen below its lower bound. Each frame starts with a capture sequence. The block holds an integration phase for a programmable number of cycles. It then enables the pixel buffer for a single sampling cycle and then strobes the comparators for one cycle. After that it walks the array one row at a time.

For every row the sequencer first clears the per-column flag register and loads it from the row's two bit-lines per column. The loading is set-only, so the register can only gain bits. The same register then gates a programmable-width update pulse onto each column's two filter-clock outputs. Only after that update does the block raise its end-of-row indication. The host then clocks the row's 2×COLS bits out serially with single-cycle shift pulses and acknowledges to move on. After the last row is acknowledged, an end-of-frame indication stays high until the next frame is started.

Top module: `event_scan_sequencer`

## Requirements
- R1: After reset, all phase indications (`integ_on`, `buf_en`, `cmp_strobe`, `row_valid`, `eor`, `eof`), both filter-clock vectors and `dout` are low.
- R2: A `start` pulse in the idle or end-of-frame phase begins integration; `integ_on` is then high for exactly max(`int_len`,1) cycles.
- R3: Directly after integration, `buf_en` is high for exactly one cycle, then `cmp_strobe` is high for exactly one cycle, then `row_valid` rises with `row_sel` = 0.
- R4: At the start of each row, the column register is cleared and then set from `bl_max`/`bl_min` of the selected row, so no flag from an earlier row carries over.
- R5: Per row, before `eor` rises, `filt_max[c]` and `filt_min[c]` equal the update pulse ANDed with column c's latched max and min bit; the pulse lasts max(`upd_len`,1) cycles. No filter clock is high at any other time.
- R6: `eor` rises after the update pulse and stays high, with `row_sel` stable, until an accepted `ack`.
- R7: Serial bit k (k = 0 … 2·COLS−1) is the max bit of column k/2 when k is even and the min bit of column k/2 when k is odd. `dout` presents bit k until a `shift_clk` pulse advances to bit k+1.
- R8: `ack` is accepted only after all 2·COLS bits of the row have been shifted. An accepted `ack` selects the next row (`row_sel`+1). Any `ack` or `shift_clk` outside its valid phase is ignored.
- R9: The `ack` of row ROWS−1 raises `eof` and drops `eor` and `row_valid`. `eof` holds until a new `start`.
- R10: `dout` is low whenever no serial bit is being presented, including after the last bit of a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (idle or end-of-frame phase only) |
| int_len | input | IW | Integration length in cycles (0 treated as 1) |
| upd_len | input | UW | Update pulse width in cycles (0 treated as 1) |
| bl_max | input | COLS | Upper-bound flag bit-lines of the selected row |
| bl_min | input | COLS | Lower-bound flag bit-lines of the selected row |
| shift_clk | input | 1 | Single-cycle serial shift request |
| ack | input | 1 | Row acknowledge |
| integ_on | output | 1 | Integration phase active |
| buf_en | output | 1 | Pixel buffer enable / sample cycle |
| cmp_strobe | output | 1 | Comparator strobe cycle |
| row_valid | output | 1 | A row is selected |
| row_sel | output | RW | Index of the selected row |
| filt_max | output | COLS | Per-column upper filter clock |
| filt_min | output | COLS | Per-column lower filter clock |
| eor | output | 1 | Row data ready for serial readout |
| dout | output | 1 | Serial data |
| eof | output | 1 | Frame fully read |

## Verification
The assertions check the following on every cycle:
- phase indications never overlap;
- filter clocks never pulse while `eor` is high or while no row is selected;
- a sample cycle is always followed by a strobe cycle;
- `row_sel` holds while `eor` is high;
- every completed row hands over to the next index;
- `dout` stays low outside readout.

Only the bench scenarios can show the rest:
- integration and update pulse lengths, including the zero settings;
- the exact bit order;
- clearing of stale flags between rows whose patterns differ;
- acknowledges and shift pulses arriving too early or too late being ignored.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE, PH_INTEG, PH_SAMPLE, PH_STROBE, PH_CLR,
        PH_LATCH, PH_UPD, PH_SHIFT, PH_ACKW, PH_EOF
    } phase_e;

    typedef struct packed {
        logic integ;
        logic buf_en;
        logic strobe;
        logic clr;
        logic load;
        logic upd;
        logic shift;
        logic eor;
        logic eof;
        logic row_valid;
    } ctl_t;

    function automatic ctl_t phase_ctl(input phase_e p);
        ctl_t c;
        c           = '0;
        c.integ     = (p == PH_INTEG);
        c.buf_en    = (p == PH_SAMPLE);
        c.strobe    = (p == PH_STROBE);
        c.clr       = (p == PH_CLR);
        c.load      = (p == PH_LATCH);
        c.upd       = (p == PH_UPD);
        c.shift     = (p == PH_SHIFT);
        c.eor       = (p == PH_SHIFT) || (p == PH_ACKW);
        c.eof       = (p == PH_EOF);
        c.row_valid = (p == PH_CLR) || (p == PH_LATCH) || (p == PH_UPD) ||
                      (p == PH_SHIFT) || (p == PH_ACKW);
        return c;
    endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_seq_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    parameter int IW   = 16,
    parameter int UW   = 8,
    localparam int RW    = $clog2(ROWS),
    localparam int NBITS = 2 * COLS,
    localparam int BW    = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          ack,
    input  logic          shift_clk,
    input  logic [IW-1:0] int_len,
    input  logic [UW-1:0] upd_len,
    output phase_e        phase,
    output logic [RW-1:0] row,
    output logic [BW-1:0] bit_idx
);
    localparam int CW0 = (IW > BW) ? IW : BW;
    localparam int CW  = (CW0 > UW) ? CW0 : UW;

    logic [CW-1:0] cnt;
    logic          integ_last;
    logic          upd_last;
    logic          shift_last;
    logic          row_last;

    assign integ_last = (cnt + CW'(1)) >= CW'(int_len);
    assign upd_last   = (cnt + CW'(1)) >= CW'(upd_len);
    assign shift_last = (cnt == CW'(NBITS - 1));
    assign row_last   = (row == RW'(ROWS - 1));
    assign bit_idx    = cnt[BW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            row   <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_EOF: begin
                    if (start) begin
                        phase <= PH_INTEG;
                        cnt   <= '0;
                    end
                end
                PH_INTEG: begin
                    if (integ_last) phase <= PH_SAMPLE;
                    else            cnt   <= cnt + CW'(1);
                end
                PH_SAMPLE: phase <= PH_STROBE;
                PH_STROBE: begin
                    phase <= PH_CLR;
                    row   <= '0;
                end
                PH_CLR:   phase <= PH_LATCH;
                PH_LATCH: begin
                    phase <= PH_UPD;
                    cnt   <= '0;
                end
                PH_UPD: begin
                    if (upd_last) begin
                        phase <= PH_SHIFT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_SHIFT: begin
                    if (shift_clk) begin
                        if (shift_last) phase <= PH_ACKW;
                        else            cnt   <= cnt + CW'(1);
                    end
                end
                PH_ACKW: begin
                    if (ack) begin
                        if (row_last) begin
                            phase <= PH_EOF;
                        end else begin
                            row   <= row + RW'(1);
                            phase <= PH_CLR;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scan_col_reg.sv
module scan_col_reg #(
    parameter int COLS = 64,
    localparam int BW  = $clog2(2 * COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            load,
    input  logic            upd,
    input  logic            shift,
    input  logic [BW-1:0]   bit_idx,
    input  logic [COLS-1:0] bl_max,
    input  logic [COLS-1:0] bl_min,
    output logic [COLS-1:0] filt_max,
    output logic [COLS-1:0] filt_min,
    output logic            dout
);
    logic [COLS-1:0] q_max;
    logic [COLS-1:0] q_min;
    logic [BW-2:0]   col;

    // set-only capture: a row can only add flags after the clear cycle
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q_max <= '0;
            q_min <= '0;
        end else if (load) begin
            q_max <= q_max | bl_max;
            q_min <= q_min | bl_min;
        end
    end

    assign filt_max = {COLS{upd}} & q_max;
    assign filt_min = {COLS{upd}} & q_min;

    assign col  = bit_idx[BW-1:1];
    assign dout = shift & (bit_idx[0] ? q_min[col] : q_max[col]);

endmodule

// File: rtl/event_scan_sequencer.sv
module event_scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    parameter int IW   = 16,
    parameter int UW   = 8,
    localparam int RW  = $clog2(ROWS),
    localparam int BW  = $clog2(2 * COLS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [IW-1:0]   int_len,
    input  logic [UW-1:0]   upd_len,
    input  logic [COLS-1:0] bl_max,
    input  logic [COLS-1:0] bl_min,
    input  logic            shift_clk,
    input  logic            ack,
    output logic            integ_on,
    output logic            buf_en,
    output logic            cmp_strobe,
    output logic            row_valid,
    output logic [RW-1:0]   row_sel,
    output logic [COLS-1:0] filt_max,
    output logic [COLS-1:0] filt_min,
    output logic            eor,
    output logic            dout,
    output logic            eof
);
    phase_e        phase;
    ctl_t          ctl;
    logic [BW-1:0] bit_idx;

    scan_fsm #(.ROWS(ROWS), .COLS(COLS), .IW(IW), .UW(UW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ack       (ack),
        .shift_clk (shift_clk),
        .int_len   (int_len),
        .upd_len   (upd_len),
        .phase     (phase),
        .row       (row_sel),
        .bit_idx   (bit_idx)
    );

    assign ctl = phase_ctl(phase);

    scan_col_reg #(.COLS(COLS)) u_cols (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctl.clr),
        .load     (ctl.load),
        .upd      (ctl.upd),
        .shift    (ctl.shift),
        .bit_idx  (bit_idx),
        .bl_max   (bl_max),
        .bl_min   (bl_min),
        .filt_max (filt_max),
        .filt_min (filt_min),
        .dout     (dout)
    );

    assign integ_on   = ctl.integ;
    assign buf_en     = ctl.buf_en;
    assign cmp_strobe = ctl.strobe;
    assign row_valid  = ctl.row_valid;
    assign eor        = ctl.eor;
    assign eof        = ctl.eof;

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int ROWS = 64,
    parameter int COLS = 64,
    localparam int RW  = $clog2(ROWS)
) (
    input logic            clk,
    input logic            rst,
    input logic            integ_on,
    input logic            buf_en,
    input logic            cmp_strobe,
    input logic            row_valid,
    input logic [RW-1:0]   row_sel,
    input logic [COLS-1:0] filt_max,
    input logic [COLS-1:0] filt_min,
    input logic            eor,
    input logic            dout,
    input logic            eof
);
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({integ_on, buf_en, cmp_strobe, eor, eof})); // R3

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        buf_en |=> (cmp_strobe && !buf_en)); // R3

    AST_FILT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ((filt_max | filt_min) != '0) |-> (row_valid && !eor)); // R5

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        ($past(eor) && eor) |-> $stable(row_sel)); // R6

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        ($past(eor) && !eor && row_valid) |-> (row_sel == RW'($past(row_sel) + 1'b1))); // R8

    AST_EOF_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        ($past(eor) && !eor && !row_valid) |-> (eof && $past(row_sel) == RW'(ROWS - 1))); // R9

    AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !eor |-> !dout); // R10

endmodule

bind event_scan_sequencer scan_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .integ_on   (integ_on),
    .buf_en     (buf_en),
    .cmp_strobe (cmp_strobe),
    .row_valid  (row_valid),
    .row_sel    (row_sel),
    .filt_max   (filt_max),
    .filt_min   (filt_min),
    .eor        (eor),
    .dout       (dout),
    .eof        (eof)
);

// File: tb/event_scan_sequencer_tb.sv
module event_scan_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 5;
    localparam int COLS = 6;
    localparam int RW   = $clog2(ROWS);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [15:0]     int_len = '0;
    logic [7:0]      upd_len = '0;
    logic [COLS-1:0] bl_max;
    logic [COLS-1:0] bl_min;
    logic            shift_clk = 1'b0;
    logic            ack = 1'b0;
    logic            integ_on, buf_en, cmp_strobe, row_valid, eor, dout, eof;
    logic [RW-1:0]   row_sel;
    logic [COLS-1:0] filt_max, filt_min;

    int checks = 0;
    int errors = 0;
    int seed   = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    event_scan_sequencer #(.ROWS(ROWS), .COLS(COLS)) u_dut (
        .clk(clk), .rst(rst), .start(start), .int_len(int_len), .upd_len(upd_len),
        .bl_max(bl_max), .bl_min(bl_min), .shift_clk(shift_clk), .ack(ack),
        .integ_on(integ_on), .buf_en(buf_en), .cmp_strobe(cmp_strobe),
        .row_valid(row_valid), .row_sel(row_sel), .filt_max(filt_max),
        .filt_min(filt_min), .eor(eor), .dout(dout), .eof(eof)
    );

    function automatic bit pmax(int s, int r, int c);
        return (c == (r + s) % COLS) || (((r * 3 + c + s) % 4) == 0);
    endfunction

    function automatic bit pmin(int s, int r, int c);
        return ((r + 2 * c + s) % 3) == 0;
    endfunction

    function automatic logic [COLS-1:0] vmax(int s, int r);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[c] = pmax(s, r, c);
        return v;
    endfunction

    function automatic logic [COLS-1:0] vmin(int s, int r);
        logic [COLS-1:0] v;
        for (int c = 0; c < COLS; c++) v[c] = pmin(s, r, c);
        return v;
    endfunction

    always_comb begin
        bl_max = vmax(seed, int'(row_sel));
        bl_min = vmin(seed, int'(row_sel));
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input int s, input int ilen, input int ulen);
        int n;
        int exp_i;
        int exp_u;
        int eb;
        seed    = s;
        int_len = 16'(ilen);
        upd_len = 8'(ulen);
        exp_i   = (ilen == 0) ? 1 : ilen;
        exp_u   = (ulen == 0) ? 1 : ulen;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (integ_on) begin
            n++;
            @(negedge clk);
        end
        chk("R2 integration length", n, exp_i);
        chk("R3 sample cycle", int'(buf_en), 1);
        @(negedge clk);
        chk("R3 strobe cycle", int'(cmp_strobe), 1);
        chk("R3 buffer off", int'(buf_en), 0);
        @(negedge clk);
        chk("R3 first row selected", int'(row_valid), 1);
        chk("R3 first row index", int'(row_sel), 0);
        for (int r = 0; r < ROWS; r++) begin
            n = 0;
            while (!eor) begin
                if ((filt_max | filt_min) != '0) begin
                    n++;
                    chk("R5 filt_max gating", int'(filt_max), int'(vmax(s, r)));
                    chk("R5 filt_min gating", int'(filt_min), int'(vmin(s, r)));
                end
                @(negedge clk);
            end
            chk("R5 update width", n, exp_u);
            chk("R6 row index at eor", int'(row_sel), r);
            // early ack must not advance or disturb the shift position
            ack = 1'b1;
            @(negedge clk) ack = 1'b0;
            chk("R8 early ack row", int'(row_sel), r);
            chk("R8 early ack eor", int'(eor), 1);
            for (int k = 0; k < 2 * COLS; k++) begin
                eb = (k % 2 == 1) ? int'(pmin(s, r, k / 2)) : int'(pmax(s, r, k / 2));
                chk("R7 R4 serial bit", int'(dout), eb);
                if (k % 2 == 1) begin
                    @(negedge clk);
                    chk("R7 bit held", int'(dout), eb);
                end
                shift_clk = 1'b1;
                @(negedge clk) shift_clk = 1'b0;
            end
            chk("R6 eor after shift", int'(eor), 1);
            chk("R10 dout idle", int'(dout), 0);
            shift_clk = 1'b1;
            @(negedge clk) shift_clk = 1'b0;
            chk("R8 late shift ignored row", int'(row_sel), r);
            chk("R8 late shift ignored eor", int'(eor), 1);
            ack = 1'b1;
            @(negedge clk) ack = 1'b0;
        end
        chk("R9 eof", int'(eof), 1);
        chk("R9 eor low", int'(eor), 0);
        chk("R9 row_valid low", int'(row_valid), 0);
        ack = 1'b1;
        shift_clk = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        shift_clk = 1'b0;
        @(negedge clk);
        chk("R9 eof holds", int'(eof), 1);
        chk("R10 dout after frame", int'(dout), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 integ_on", int'(integ_on), 0);
        chk("R1 buf_en", int'(buf_en), 0);
        chk("R1 cmp_strobe", int'(cmp_strobe), 0);
        chk("R1 row_valid", int'(row_valid), 0);
        chk("R1 eor", int'(eor), 0);
        chk("R1 eof", int'(eof), 0);
        chk("R1 filters", int'(filt_max | filt_min), 0);
        chk("R10 dout at reset", int'(dout), 0);
        ack = 1'b1;
        shift_clk = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        shift_clk = 1'b0;
        @(negedge clk);
        chk("R8 idle ack ignored", int'(row_valid | eor | integ_on), 0);
        run_frame(0, 0, 0);
        run_frame(1, 5, 3);
        run_frame(2, 12, 1);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule